// File: doc/BRIEF.md
# Cascaded Loss-of-Signal Clock Fallback Chain

This block chooses which recovered line clock drives the master system clock in a loop-timed system with several lines. Each line has a detector that runs on its own recovered clock. The detector watches the received data for long runs of zeros and raises a loss flag when it sees one. The flags cross into the system clock domain. There they feed a fall-through chain of stages, and the chain produces the index of the selected source.

Position 0 of the chain is the master. A healthy stage offers its own line. A stage in loss of signal, or a position disabled by configuration, passes on whatever the next stage offers. The result is that the healthy line closest to the master is selected. The local reference is selected only when every enabled position is lost.

A configuration input sets which line sits at each position, and a per-position enable removes a line from the fallback path, for example a line that is already loop-timed to this node. Every change of the selected index produces a single-cycle event pulse.

Top module: `clock_fallback_chain`

## Requirements
- R1: A line's loss flag rises on the line clock edge that samples its ZERO_RUN-th consecutive zero (default 175, legal range 100 to 250). ZERO_RUN-1 zeros followed by a one leave the flag clear.
- R2: A received one restarts the zero count, so two runs of ZERO_RUN-1 zeros separated by a single one never set the flag.
- R3: While a line is lost, its first received one opens a window of WIN_LEN samples that starts with that one. At the end of the window the flag clears if the window held at least WIN_ONES ones (defaults 16 and 12). Otherwise the flag stays set and the detector waits for the next one.
- R4: After reset, all loss flags read 1, `sel_src` equals N_LINES (the local reference) and `sel_change` is 0. `sel_src` never exceeds N_LINES.
- R5: While the line at position 0 (`cfg_order` bits [IW-1:0]) is enabled and healthy, it is selected.
- R6: When the master is lost, the selection is the lowest-numbered enabled position whose line is healthy. A selected line is never flagged lost.
- R7: `sel_src` equals N_LINES exactly when every enabled position holds a lost line.
- R8: Position k takes line `cfg_order[k*IW +: IW]` and takes part only while `cfg_use[k]` is 1. A line at a disabled position is never selected, even when it is healthy and all others are lost. A configuration change takes effect on the next system clock edge.
- R9: `sel_change` is high for exactly one system clock cycle at each change of `sel_src`, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; selection and flag outputs are in this domain |
| rst | input | 1 | Active-high reset, synchronous to sys_clk, resynchronised per line |
| line_clk | input | N_LINES | Recovered clock of each line |
| line_data | input | N_LINES | Received data of each line, sampled on its line_clk rising edge |
| cfg_order | input | N_LINES*IW | Line index for each chain position, position 0 in the low bits |
| cfg_use | input | N_LINES | Enable for each chain position |
| los | output | N_LINES | Loss-of-signal flag per line, synchronised to sys_clk |
| sel_src | output | SW | Selected line index; N_LINES means local reference |
| sel_change | output | 1 | One-cycle pulse when sel_src changes |

## Verification
The bench probes the zero-run threshold from both sides. A detector that counts one sample too many or too few either misses the flag after exactly ZERO_RUN zeros or raises it after ZERO_RUN-1. A single one between two long runs exposes a detector that fails to restart its count. The recovery cases use windows holding exactly WIN_ONES and WIN_ONES-1 ones, placed after leading zeros, so a window that opens early or uses the wrong comparison is caught. On the selection side, the bench removes the master, all lines and chosen positions. This catches a chain that prefers the wrong neighbour, ignores the position enables, or drops or repeats the change pulse.

// File: rtl/losfb_pkg.sv
package losfb_pkg;

    // Legal range of the zero-run threshold
    localparam int RUN_LIMIT_LO = 100;
    localparam int RUN_LIMIT_HI = 250;

    // Recovery sub-state of a detector that is in loss of signal
    typedef enum logic {
        AWAIT_ONE = 1'b0,
        IN_WINDOW = 1'b1
    } clr_state_e;

    // Width of a line index
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a selection code, which also encodes the local reference (value n)
    function automatic int sel_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/los_detector.sv
module los_detector
    import losfb_pkg::*;
#(
    parameter int ZERO_RUN = 175,
    parameter int WIN_LEN  = 16,
    parameter int WIN_ONES = 12,
    localparam int ZW = $clog2(ZERO_RUN + 1),
    localparam int WW = $clog2(WIN_LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic data,
    output logic los
);

    logic [1:0]  rst_sync;
    logic        lrst;
    logic [ZW-1:0] zrun;
    logic [WW-1:0] wcnt;
    logic [WW-1:0] ones;
    logic [WW-1:0] wcnt_nxt;
    logic [WW-1:0] ones_nxt;
    clr_state_e    st;
    logic          los_q;

    // Reset is brought into the line clock domain
    always_ff @(posedge clk) begin
        rst_sync <= {rst_sync[0], rst};
    end
    assign lrst = rst_sync[1];

    assign wcnt_nxt = wcnt + WW'(1);
    assign ones_nxt = ones + WW'(data);

    always_ff @(posedge clk) begin
        if (lrst) begin
            zrun  <= '0;
            wcnt  <= '0;
            ones  <= '0;
            st    <= AWAIT_ONE;
            los_q <= 1'b1;
        end else begin
            // Consecutive zero counter, saturating at the threshold
            if (data) begin
                zrun <= '0;
            end else if (zrun != ZW'(ZERO_RUN)) begin
                zrun <= zrun + ZW'(1);
            end

            if (!los_q) begin
                st <= AWAIT_ONE;
                if (!data && zrun == ZW'(ZERO_RUN - 1)) begin
                    los_q <= 1'b1;
                end
            end else begin
                unique case (st)
                    AWAIT_ONE: begin
                        if (data) begin
                            st   <= IN_WINDOW;
                            wcnt <= WW'(1);
                            ones <= WW'(1);
                        end
                    end
                    IN_WINDOW: begin
                        wcnt <= wcnt_nxt;
                        ones <= ones_nxt;
                        if (wcnt_nxt == WW'(WIN_LEN)) begin
                            st <= AWAIT_ONE;
                            if (ones_nxt >= WW'(WIN_ONES)) begin
                                los_q <= 1'b0;
                            end
                        end
                    end
                    default: st <= AWAIT_ONE;
                endcase
            end
        end
    end

    assign los = los_q;

endmodule

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] meta;
    logic [WIDTH-1:0] held;

    // Two-stage crossing; flags come up as lost
    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '1;
            held <= '1;
        end else begin
            meta <= din;
            held <= meta;
        end
    end

    assign dout = held;

endmodule

// File: rtl/fallback_chain.sv
module fallback_chain
    import losfb_pkg::*;
#(
    parameter int N_LINES = 4,
    localparam int IW = idx_width(N_LINES),
    localparam int SW = sel_width(N_LINES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_LINES-1:0]    los,
    input  logic [N_LINES*IW-1:0] order,
    input  logic [N_LINES-1:0]    use_pos,
    output logic [SW-1:0]         sel,
    output logic                  change
);

    logic [SW-1:0] link [N_LINES+1];
    logic [SW-1:0] sel_q;
    logic          change_q;

    // Tail of the chain offers the local reference
    assign link[N_LINES] = SW'(N_LINES);

    // Each stage offers its own line when healthy, else what the next stage offers
    for (genvar k = 0; k < N_LINES; k++) begin : g_stage
        logic [IW-1:0] line;
        logic          ok;
        assign line    = order[k*IW +: IW];
        assign ok      = use_pos[k] && (int'(line) < N_LINES) && !los[line];
        assign link[k] = ok ? SW'(line) : link[k+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= SW'(N_LINES);
            change_q <= 1'b0;
        end else begin
            sel_q    <= link[0];
            change_q <= (link[0] != sel_q);
        end
    end

    assign sel    = sel_q;
    assign change = change_q;

endmodule

// File: rtl/clock_fallback_chain.sv
module clock_fallback_chain
    import losfb_pkg::*;
#(
    parameter int N_LINES  = 4,
    parameter int ZERO_RUN = 175,
    parameter int WIN_LEN  = 16,
    parameter int WIN_ONES = 12,
    localparam int IW = idx_width(N_LINES),
    localparam int SW = sel_width(N_LINES)
) (
    input  logic                  sys_clk,
    input  logic                  rst,
    input  logic [N_LINES-1:0]    line_clk,
    input  logic [N_LINES-1:0]    line_data,
    input  logic [N_LINES*IW-1:0] cfg_order,
    input  logic [N_LINES-1:0]    cfg_use,
    output logic [N_LINES-1:0]    los,
    output logic [SW-1:0]         sel_src,
    output logic                  sel_change
);

    logic [N_LINES-1:0] los_raw;
    logic [N_LINES-1:0] los_sys;

    // One detector per line, each in its own recovered clock domain
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        los_detector #(
            .ZERO_RUN (ZERO_RUN),
            .WIN_LEN  (WIN_LEN),
            .WIN_ONES (WIN_ONES)
        ) u_det (
            .clk  (line_clk[i]),
            .rst  (rst),
            .data (line_data[i]),
            .los  (los_raw[i])
        );
    end

    flag_sync #(
        .WIDTH (N_LINES)
    ) u_sync (
        .clk  (sys_clk),
        .rst  (rst),
        .din  (los_raw),
        .dout (los_sys)
    );

    fallback_chain #(
        .N_LINES (N_LINES)
    ) u_chain (
        .clk     (sys_clk),
        .rst     (rst),
        .los     (los_sys),
        .order   (cfg_order),
        .use_pos (cfg_use),
        .sel     (sel_src),
        .change  (sel_change)
    );

    assign los = los_sys;

endmodule

// File: rtl/clock_fallback_chain_chk.sv
module clock_fallback_chain_chk
    import losfb_pkg::*;
#(
    parameter int N_LINES = 4,
    localparam int IW = idx_width(N_LINES),
    localparam int SW = sel_width(N_LINES)
) (
    input  logic                  sys_clk,
    input  logic                  rst,
    input  logic [N_LINES*IW-1:0] cfg_order,
    input  logic [N_LINES-1:0]    cfg_use,
    input  logic [N_LINES-1:0]    los,
    input  logic [SW-1:0]         sel_src,
    input  logic                  sel_change
);

    logic [N_LINES-1:0]    los_d;
    logic [N_LINES*IW-1:0] ord_d;
    logic [N_LINES-1:0]    use_d;
    logic [SW-1:0]         sel_d;
    logic                  all_lost;
    logic                  in_chain;
    logic                  sel_healthy;

    // Previous-cycle view of the inputs the selection was made from
    always_ff @(posedge sys_clk) begin
        if (rst) begin
            los_d <= '1;
            ord_d <= '0;
            use_d <= '0;
            sel_d <= SW'(N_LINES);
        end else begin
            los_d <= los;
            ord_d <= cfg_order;
            use_d <= cfg_use;
            sel_d <= sel_src;
        end
    end

    always_comb begin
        all_lost    = 1'b1;
        in_chain    = 1'b0;
        sel_healthy = 1'b1;
        for (int k = 0; k < N_LINES; k++) begin
            if (use_d[k] && !los_d[ord_d[k*IW +: IW]]) all_lost = 1'b0;
            if (use_d[k] && SW'(ord_d[k*IW +: IW]) == sel_src) in_chain = 1'b1;
        end
        for (int l = 0; l < N_LINES; l++) begin
            if (SW'(l) == sel_src) sel_healthy = !los_d[l];
        end
    end

    a_r4_sel_range: assert property (@(posedge sys_clk) disable iff (rst)
        sel_src <= SW'(N_LINES));

    a_r7_ref_means_all_lost: assert property (@(posedge sys_clk) disable iff (rst)
        (sel_src == SW'(N_LINES)) |-> all_lost);

    a_r7_all_lost_means_ref: assert property (@(posedge sys_clk) disable iff (rst)
        all_lost |-> (sel_src == SW'(N_LINES)));

    a_r6_selected_healthy: assert property (@(posedge sys_clk) disable iff (rst)
        (sel_src != SW'(N_LINES)) |-> sel_healthy);

    a_r8_selected_enabled: assert property (@(posedge sys_clk) disable iff (rst)
        (sel_src != SW'(N_LINES)) |-> in_chain);

    a_r9_change_flagged: assert property (@(posedge sys_clk) disable iff (rst)
        (sel_src != sel_d) |-> sel_change);

    a_r9_no_spurious_pulse: assert property (@(posedge sys_clk) disable iff (rst)
        sel_change |-> (sel_src != sel_d));

endmodule

bind clock_fallback_chain clock_fallback_chain_chk #(
    .N_LINES (N_LINES)
) u_chk (
    .sys_clk    (sys_clk),
    .rst        (rst),
    .cfg_order  (cfg_order),
    .cfg_use    (cfg_use),
    .los        (los),
    .sel_src    (sel_src),
    .sel_change (sel_change)
);

// File: tb/sim_clock_fallback_chain.sv
`timescale 1ns/1ps
module sim_clock_fallback_chain;

    localparam int N    = 4;
    localparam int THR  = 175;
    localparam int WIN  = 16;
    localparam int MINO = 12;
    localparam int REF  = N;

    logic       sys_clk = 1'b0;
    logic       lclk    = 1'b0;
    logic       rst     = 1'b1;
    logic [3:0] line_data = 4'b0000;
    logic [7:0] cfg_order = 8'b11_10_01_00;  // position k holds line k
    logic [3:0] cfg_use   = 4'b1111;
    logic [3:0] los;
    logic [2:0] sel_src;
    logic       sel_change;

    int n_tests = 0;
    int n_fail  = 0;
    int chg_cnt = 0;
    int dbl_cnt = 0;
    logic prev_chg = 1'b0;
    int mode [4];
    logic [31:0] scr [4];
    int phase = 0;
    int base;

    always #2.5 sys_clk = ~sys_clk;   // 200 MHz
    always #4   lclk    = ~lclk;

    clock_fallback_chain u0 (
        .sys_clk    (sys_clk),
        .rst        (rst),
        .line_clk   ({4{lclk}}),
        .line_data  (line_data),
        .cfg_order  (cfg_order),
        .cfg_use    (cfg_use),
        .los        (los),
        .sel_src    (sel_src),
        .sel_change (sel_change)
    );

    // Pulse bookkeeping for R9
    always @(posedge sys_clk) begin
        if (rst) begin
            prev_chg <= 1'b0;
        end else begin
            if (sel_change) chg_cnt++;
            if (sel_change && prev_chg) dbl_cnt++;
            prev_chg <= sel_change;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Modes: 0 zeros, 1 ones, 2 alternating, 3 scripted bits (LSB first)
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge lclk);
            for (int l = 0; l < 4; l++) begin
                case (mode[l])
                    0: line_data[l] = 1'b0;
                    1: line_data[l] = 1'b1;
                    2: line_data[l] = phase[0];
                    default: begin
                        line_data[l] = scr[l][0];
                        scr[l] = scr[l] >> 1;
                    end
                endcase
            end
            phase++;
        end
    endtask

    // k zeros, then one single one, then alternating data that cannot clear a flag
    task automatic zeros_then_hold(input int l, input int k);
        mode[l] = 0; tick(k);
        mode[l] = 1; tick(1);
        mode[l] = 2; tick(12);
        @(negedge sys_clk);
    endtask

    task automatic t_reset;
        repeat (20) @(negedge sys_clk);
        rst = 1'b0;
        repeat (5) @(negedge sys_clk);
        chk("R4", "los after reset", los, 4'b1111);
        chk("R4", "sel after reset", sel_src, REF);
        chk("R4", "no change after reset", chg_cnt, 0);
    endtask

    task automatic t_recover;
        base = chg_cnt;
        mode[2] = 3; scr[2] = 32'h0000_FFF0;  // window opened by first one holds 12 ones
        tick(40);
        @(negedge sys_clk);
        chk("R3", "line2 cleared with WIN_ONES ones", los[2], 0);
        chk("R6", "nearest healthy is line2", sel_src, 2);
        chk("R9", "one pulse on change", chg_cnt - base, 1);
        mode[2] = 1;
        mode[3] = 3; scr[3] = 32'h0000_07FF;  // 11 ones in window
        tick(40);
        @(negedge sys_clk);
        chk("R3", "line3 stays lost with WIN_ONES-1", los[3], 1);
        base = chg_cnt;
        scr[3] = 32'h0000_FFFF;               // rearmed window, all ones
        tick(40);
        @(negedge sys_clk);
        chk("R3", "line3 clears on later window", los[3], 0);
        chk("R6", "sel stays line2", sel_src, 2);
        chk("R9", "no pulse while stable", chg_cnt - base, 0);
        mode[3] = 1;
    endtask

    task automatic t_master;
        base = chg_cnt;
        mode[0] = 1; mode[1] = 1;
        tick(30);
        @(negedge sys_clk);
        chk("R5", "all lines healthy", los, 4'b0000);
        chk("R5", "master selected", sel_src, 0);
        chk("R9", "single pulse", chg_cnt - base, 1);
    endtask

    task automatic t_zero_run;
        zeros_then_hold(0, THR - 1);
        chk("R1", "THR-1 zeros no flag", los[0], 0);
        chk("R5", "master kept", sel_src, 0);
        zeros_then_hold(0, THR);
        chk("R1", "THR zeros sets flag", los[0], 1);
        chk("R6", "fallback to position 1", sel_src, 1);
        mode[1] = 0; tick(THR - 1);
        mode[1] = 1; tick(1);
        zeros_then_hold(1, THR - 1);
        chk("R2", "one restarts count", los[1], 0);
        chk("R2", "position 1 kept", sel_src, 1);
    endtask

    task automatic t_all_lost;
        for (int l = 0; l < 4; l++) mode[l] = 0;
        tick(THR + 2);
        for (int l = 0; l < 4; l++) mode[l] = 2;
        tick(12);
        @(negedge sys_clk);
        chk("R7", "all flags set", los, 4'b1111);
        chk("R7", "reference selected", sel_src, REF);
    endtask

    task automatic t_config;
        for (int l = 0; l < 4; l++) mode[l] = 1;
        tick(30);
        @(negedge sys_clk);
        chk("R5", "master again", sel_src, 0);
        cfg_use = 4'b1110;
        repeat (3) @(negedge sys_clk);
        chk("R8", "disabled position skipped", sel_src, 1);
        cfg_order = 8'b00_01_10_11;           // position 0 holds line 3
        repeat (3) @(negedge sys_clk);
        chk("R8", "reordered chain", sel_src, 2);
        cfg_use = 4'b0001;
        repeat (3) @(negedge sys_clk);
        chk("R8", "only position 0", sel_src, 3);
        zeros_then_hold(3, THR + 2);
        chk("R8", "healthy excluded lines unused", sel_src, REF);
        chk("R8", "other lines still healthy", los, 4'b1000);
        chk("R9", "no double-width pulse", dbl_cnt, 0);
    endtask

    initial begin
        for (int l = 0; l < 4; l++) begin
            mode[l] = 0;
            scr[l]  = '0;
        end
        t_reset();
        t_recover();
        t_master();
        t_zero_run();
        t_all_lost();
        t_config();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge sys_clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule